// File: doc/BRIEF.md
# Modified One-Hot Four-Phase Sequencer

This block is a four-state synchronous control machine. Its state lives in a four-bit register that uses a one-hot pattern with the lowest bit inverted. As a result, the first phase is the all-zero word. A register that powers up cleared therefore already sits in a defined phase, even when no reset is ever applied. Each phase is still recognised from one register bit alone, and any two legal phase words differ in exactly two bit positions.

On every clock edge where the advance strobe is high, the sequencer moves to the next phase. After the fourth phase it wraps back to the first. If the register ever holds one of the twelve codes outside the legal set, it returns to the all-zero phase on the next edge. A synchronous reset and a load port for test use complete the inputs. The outputs are the raw register, four per-phase flags and an illegal-code indicator.

Top module: `mod_onehot_seq`

## Requirements
- R1: Without any reset, the state register starts at 0000, and the first-phase flag (stateFlags bit 0) is high from time zero.
- R2: When rstSync is high at a rising edge, stateCode becomes 0000 after that edge. This takes priority over every other input.
- R3: With advance high and a legal code in the register, stateCode steps at each rising edge through 0000 → 0011 → 0101 → 1001 → 0000.
- R4: With advance low, a legal code in the register, and no reset or load, stateCode holds its value across the edge.
- R5: When the register holds any of the twelve codes outside {0000, 0011, 0101, 1001} and no reset or load is active, stateCode becomes 0000 at the next edge, whatever the value of advance.
- R6: The flags are combinational. stateFlags bit 0 is the inverse of stateCode bit 0. stateFlags bit k equals stateCode bit k for k = 1, 2, 3. In every legal code, exactly one flag is high.
- R7: illegalCode is high exactly when stateCode is not one of 0000, 0011, 0101 or 1001.
- R8: When testLoad is high at a rising edge and rstSync is low, stateCode takes the value of testValue. This overrides both advance and illegal-code recovery.
- R9: Any two of the four legal codes differ in exactly two bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstSync | input | 1 | Synchronous reset to 0000; optional, may be tied low |
| advance | input | 1 | Step to the next phase at this edge |
| testLoad | input | 1 | Test-only: load testValue into the state register |
| testValue | input | 4 | Test-only value to load |
| stateCode | output | 4 | Raw state register |
| stateFlags | output | 4 | Per-phase flags; bit n is high in phase n |
| illegalCode | output | 1 | High while the register holds a non-legal code |

## Verification
On every cycle, the assertions check the following:
- each legal phase's successor, and holding when advance is low;
- the return to zero from an illegal code;
- load and reset results;
- the single-flag property in legal phases, and that illegalCode is cleared after recovery.

Only the bench's scenarios can show the start in 0000 with no reset ever applied, and the pairwise two-bit distance between the codes seen in one full pass. The bench also walks through recovery from each of the twelve illegal values, loaded one by one, while advance takes both levels.

// File: rtl/mod_onehot_seq_pkg.sv
package mod_onehot_seq_pkg;
  localparam int CODE_W = 4;
  localparam int PHASES = 4;

  typedef enum logic [CODE_W-1:0] {
    PH_FIRST  = 4'b0000,
    PH_SECOND = 4'b0011,
    PH_THIRD  = 4'b0101,
    PH_FOURTH = 4'b1001
  } phaseT;

  typedef struct packed {
    logic clear;
    logic load;
    logic step;
  } seqStrobeT;

  function automatic logic codeIsLegal(input logic [CODE_W-1:0] c);
    return (c == PH_FIRST) || (c == PH_SECOND) || (c == PH_THIRD) || (c == PH_FOURTH);
  endfunction

  function automatic logic [CODE_W-1:0] succCode(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] n;
    case (c)
      PH_FIRST:  n = PH_SECOND;
      PH_SECOND: n = PH_THIRD;
      PH_THIRD:  n = PH_FOURTH;
      default:   n = PH_FIRST;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/mod_onehot_seq_ctrl.sv
module mod_onehot_seq_ctrl
  import mod_onehot_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstSync,
  input  logic      advance,
  input  logic      testLoad,
  input  logic      legalNow,
  output seqStrobeT strobes
);
  // Priority: reset, then test load, then illegal recovery, then step.
  always_comb begin
    strobes.clear = rstSync || (!testLoad && !legalNow);
    strobes.load  = !rstSync && testLoad;
    strobes.step  = !rstSync && !testLoad && legalNow && advance;
  end

  // R2 / R8: strobes never conflict
  a_r8_strobe_exclusive: assert property (@(posedge clk)
    $countones({strobes.clear, strobes.load, strobes.step}) <= 1);
endmodule

// File: rtl/mod_onehot_seq_path.sv
module mod_onehot_seq_path
  import mod_onehot_seq_pkg::*;
(
  input  logic              clk,
  input  seqStrobeT         strobes,
  input  logic [CODE_W-1:0] loadValue,
  output logic [CODE_W-1:0] codeOut,
  output logic [PHASES-1:0] flagsOut,
  output logic              legalOut
);
  // Power-up value doubles as the first phase.
  logic [CODE_W-1:0] codeReg = PH_FIRST;

  always_ff @(posedge clk) begin
    if (strobes.clear)     codeReg <= PH_FIRST;
    else if (strobes.load) codeReg <= loadValue;
    else if (strobes.step) codeReg <= succCode(codeReg);
  end

  // Single-bit decode: phase 0 is bit 0 low, phase k is bit k high.
  always_comb begin
    flagsOut[0] = ~codeReg[0];
    for (int k = 1; k < PHASES; k++) flagsOut[k] = codeReg[k];
  end

  assign codeOut  = codeReg;
  assign legalOut = codeIsLegal(codeReg);

  a_r3_first_to_second: assert property (@(posedge clk) disable iff (strobes.clear && strobes.load)
    (codeReg == 4'b0000 && strobes.step) |=> codeReg == 4'b0011);
  a_r3_second_to_third: assert property (@(posedge clk)
    (codeReg == 4'b0011 && strobes.step) |=> codeReg == 4'b0101);
  a_r3_third_to_fourth: assert property (@(posedge clk)
    (codeReg == 4'b0101 && strobes.step) |=> codeReg == 4'b1001);
  a_r3_fourth_wraps: assert property (@(posedge clk)
    (codeReg == 4'b1001 && strobes.step) |=> codeReg == 4'b0000);
  a_r4_hold_idle: assert property (@(posedge clk)
    !(strobes.clear || strobes.load || strobes.step) |=> $stable(codeReg));
  a_r6_single_flag: assert property (@(posedge clk)
    legalOut |-> $countones(flagsOut) == 1);
  a_r8_load_value: assert property (@(posedge clk)
    strobes.load |=> codeReg == $past(loadValue));
endmodule

// File: rtl/mod_onehot_seq.sv
module mod_onehot_seq
  import mod_onehot_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstSync,
  input  logic              advance,
  input  logic              testLoad,
  input  logic [CODE_W-1:0] testValue,
  output logic [CODE_W-1:0] stateCode,
  output logic [PHASES-1:0] stateFlags,
  output logic              illegalCode
);
  seqStrobeT strobes;
  logic      legalNow;

  mod_onehot_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstSync  (rstSync),
    .advance  (advance),
    .testLoad (testLoad),
    .legalNow (legalNow),
    .strobes  (strobes)
  );

  mod_onehot_seq_path u_path (
    .clk       (clk),
    .strobes   (strobes),
    .loadValue (testValue),
    .codeOut   (stateCode),
    .flagsOut  (stateFlags),
    .legalOut  (legalNow)
  );

  assign illegalCode = !legalNow;

  a_r2_reset_clears: assert property (@(posedge clk)
    rstSync |=> stateCode == 4'b0000);
  a_r5_recover: assert property (@(posedge clk) disable iff (rstSync)
    (illegalCode && !testLoad) |=> stateCode == 4'b0000);
  a_r7_recover_clears_flag: assert property (@(posedge clk) disable iff (rstSync)
    (illegalCode && !testLoad) |=> !illegalCode);
endmodule

// File: tb/mod_onehot_seq_bench.sv
module mod_onehot_seq_bench;
  logic       clk = 1'b0;
  logic       rstSync = 1'b0;
  logic       advance = 1'b0;
  logic       testLoad = 1'b0;
  logic [3:0] testValue = 4'b0000;
  logic [3:0] stateCode;
  logic [3:0] stateFlags;
  logic       illegalCode;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [3:0] expCode = 4'b0000;

  always #5 clk = ~clk;

  mod_onehot_seq u_mod_onehot_seq (
    .clk(clk), .rstSync(rstSync), .advance(advance), .testLoad(testLoad),
    .testValue(testValue), .stateCode(stateCode), .stateFlags(stateFlags),
    .illegalCode(illegalCode)
  );

  function automatic bit legalB(input logic [3:0] c);
    return c == 4'b0000 || c == 4'b0011 || c == 4'b0101 || c == 4'b1001;
  endfunction

  function automatic logic [3:0] nextB(input logic [3:0] c);
    if (c == 4'b0000) return 4'b0011;
    if (c == 4'b0011) return 4'b0101;
    if (c == 4'b0101) return 4'b1001;
    return 4'b0000;
  endfunction

  function automatic logic [3:0] flagsB(input logic [3:0] c);
    return {c[3], c[2], c[1], ~c[0]};
  endfunction

  function automatic logic [3:0] modelB(input logic [3:0] c, input bit r, input bit ld,
                                        input logic [3:0] v, input bit adv);
    if (r) return 4'b0000;
    if (ld) return v;
    if (!legalB(c)) return 4'b0000;
    if (adv) return nextB(c);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic checkOutputs(input string req);
    check(stateCode == expCode, req, stateCode, expCode);
    check(stateFlags == flagsB(expCode), "R6", stateFlags, flagsB(expCode));
    check(illegalCode == !legalB(expCode), "R7", {3'b0, illegalCode}, {3'b0, !legalB(expCode)});
    if (legalB(expCode))
      check($countones(stateFlags) == 1, "R6", stateFlags, flagsB(expCode));
  endtask

  // Drive at the falling edge, compare 1 ns after the rising edge.
  task automatic cycle(input bit r, input bit ld, input logic [3:0] v, input bit adv, input string req);
    @(negedge clk);
    rstSync = r; testLoad = ld; testValue = v; advance = adv;
    expCode = modelB(expCode, r, ld, v, adv);
    @(posedge clk);
    #1;
    checkOutputs(req);
  endtask

  initial begin
    logic [3:0] seen [4];
    void'($urandom(32'd1234));
    #1;
    checkOutputs("R1");
    check(stateFlags[0] == 1'b1, "R1", stateFlags, 4'b0001);
    // R1 and R3: a full pass with no reset ever applied.
    for (int i = 0; i < 4; i++) begin
      seen[i] = stateCode;
      cycle(0, 0, 4'h0, 1, "R3");
    end
    check(stateCode == 4'b0000, "R3", stateCode, 4'b0000);
    // R9: pairwise distance of the codes seen in the pass.
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++)
        check($countones(seen[a] ^ seen[b]) == 2, "R9", seen[a] ^ seen[b], 4'b0011);
    // R4: hold in every phase.
    for (int i = 0; i < 4; i++) begin
      cycle(0, 0, 4'h0, 0, "R4");
      cycle(0, 0, 4'h0, 0, "R4");
      cycle(0, 0, 4'h0, 1, "R3");
    end
    // R2: reset beats load and advance.
    cycle(0, 0, 4'h0, 1, "R3");
    cycle(1, 1, 4'b1111, 1, "R2");
    // R5 / R8: each illegal value, loaded, then recovered with either advance level.
    for (int v = 0; v < 16; v++) begin
      if (!legalB(4'(v))) begin
        cycle(0, 1, 4'(v), 0, "R8");
        cycle(0, 0, 4'h0, v[0], "R5");
      end
    end
    // R8: load overrides recovery from an illegal code.
    cycle(0, 1, 4'b1111, 0, "R8");
    cycle(0, 1, 4'b0101, 1, "R8");
    // Random mix.
    for (int i = 0; i < 400; i++) begin
      int unsigned r = $urandom % 100;
      cycle(r < 4, (r >= 4 && r < 14), 4'($urandom), ($urandom % 3) != 0, "R3");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%b expected=%b", 1'b0, 1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule